// File: doc/BRIEF.md
# Core Interrupt Pending and Delivery Gate

This block keeps the eight pending-interrupt flags of a processor core and decides, cycle by cycle, whether the pipeline should be told to take an interrupt. Software or neighbouring logic sets single flags with a post strobe and removes them with a clear strobe or a clear-all strobe. Each strobe has its own bit index. An index that names no flag is refused and reported on an error output.

A free-running cycle counter is compared with a compare register. When the two are equal and the counter is not zero, the flag chosen by a three-bit timer-position register is set. It stays set until something clears it. The flags are ANDed with an eight-bit mask. A request goes to the pipeline only when global enable is 1 and both the error-level and exception-level status bits are 0. A two-state delivery machine registers that decision and hands the masked flags and the mask to the handler.

The delivery machine has two states. `GATE_IDLE` moves to `GATE_FIRE` when the gate condition is true. `GATE_FIRE` stays in `GATE_FIRE` while the condition holds, and returns to `GATE_IDLE` when it drops. `GATE_IDLE` stays in `GATE_IDLE` while the condition is false.

Top module: `core_irq_ctl`

## Requirements
- R1: A post strobe with index 0..7 sets only that flag of `pending` at the next clock edge. All other flags keep their value.
- R2: A clear strobe with index 0..7 clears only that flag. A clear-all strobe zeroes all of `pending` at the next edge and overrides every post, clear and timer set in that cycle.
- R3: When a post and a clear name the same flag in one cycle, the flag ends up clear. A clear on the timer-position flag also beats a timer set on that flag in the same cycle.
- R4: A post or clear with an index of 8..15 changes no flag. `idx_err` is 1 in the cycle after such a strobe, and 0 in the cycle after a cycle with no such strobe.
- R5: `count` loads `cnt_wdata` on `cnt_wr`. Otherwise it adds one per cycle while `cnt_en` is 1 and holds while `cnt_en` is 0. It wraps from all ones to zero. `cmp_wr` loads the compare register and `pos_wr` loads the three-bit timer position.
- R6: A timer match exists in a cycle when count equals compare and count is not zero. On a match, the flag at the timer position is set at the next edge. Count and compare both equal to zero never set a flag.
- R7: A timer-set flag stays set after count moves past compare, until it is cleared.
- R8: `take_irq` is registered. In a cycle after reset it equals the value that `gie & ~erl & ~exl & |(mask & pending)` had in the previous cycle.
- R9: `hnd_mask` and `hnd_pend` are registered copies of `mask` and `mask & pending` from the previous cycle.
- R10: `any_pend` is combinational. It is 1 when any flag is set or a timer match exists in the current cycle.
- R11: Reset (`rst_n` low) clears every flag, count, compare, timer position, `take_irq`, `idx_err` and both handler outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_en | input | 1 | Post strobe |
| post_idx | input | 4 | Flag index for post |
| clr_en | input | 1 | Clear strobe |
| clr_idx | input | 4 | Flag index for clear |
| clr_all | input | 1 | Clear every flag |
| cnt_en | input | 1 | Counter advance enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 32 | Counter load value |
| cmp_wr | input | 1 | Compare load strobe |
| cmp_wdata | input | 32 | Compare load value |
| pos_wr | input | 1 | Timer-position load strobe |
| pos_wdata | input | 3 | Flag index used by the timer |
| gie | input | 1 | Global interrupt enable |
| erl | input | 1 | Error-level status bit |
| exl | input | 1 | Exception-level status bit |
| mask | input | 8 | Per-flag delivery mask |
| pending | output | 8 | Pending flags |
| any_pend | output | 1 | Any flag set or timer match now |
| take_irq | output | 1 | Registered take-interrupt request |
| hnd_mask | output | 8 | Registered mask for the handler |
| hnd_pend | output | 8 | Registered masked flags for the handler |
| idx_err | output | 1 | Out-of-range index seen last cycle |
| count | output | 32 | Cycle counter value |

## Verification
The bench aims at these priority corners:
- A post and a clear on the same flag. A design that ordered them wrongly would leave the flag set.
- Clear-all together with a post. A design that let the post through would leave a stray flag.
- A timer match landing in a cycle that also clears that flag.

It runs the counter through a zero-equals-zero compare, which must set nothing. A design that dropped the nonzero test would raise a spurious timer interrupt there. It also moves the counter past compare to confirm the flag stays sticky, and wraps the counter from all ones to zero.

It asserts error level and exception level one at a time with enable high. A gate that checked only enable would keep `take_irq` high. Indexes 8 and above are driven to show that truncating the index corrupts a low flag.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef enum logic [0:0] {
        GATE_IDLE = 1'b0,
        GATE_FIRE = 1'b1
    } gate_state_e;

endpackage

// File: rtl/cyc_timer.sv
module cyc_timer #(
    parameter int CNT_W = 32,
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             pos_wr,
    input  logic [POS_W-1:0] pos_wdata,
    output logic [CNT_W-1:0] count_q,
    output logic [POS_W-1:0] pos_q,
    output logic             hit
);

    logic [CNT_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= cnt_wdata;
        end else if (cnt_en) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            pos_q <= '0;
        end else begin
            if (cmp_wr) cmp_q <= cmp_wdata;
            if (pos_wr) pos_q <= pos_wdata;
        end
    end

    // a zero counter never counts as a match
    assign hit = (count_q == cmp_q) && (count_q != '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr) |=> (count_q == $past(count_q) + CNT_W'(1))); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !cnt_wr) |=> $stable(count_q)); // R5
    AST_NO_ZERO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |-> !hit); // R6

endmodule

// File: rtl/pend_field.sv
module pend_field #(
    parameter int NBITS = 8,
    parameter int IDX_W = 4,
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_en,
    input  logic [IDX_W-1:0] post_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             clr_all,
    input  logic             hit,
    input  logic [POS_W-1:0] pos,
    output logic [NBITS-1:0] pend_q,
    output logic             idx_err_q
);

    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NBITS);

    logic post_bad;
    logic clr_bad;
    logic [NBITS-1:0] set_vec;
    logic [NBITS-1:0] kill_vec;
    logic [NBITS-1:0] pend_d;

    assign post_bad = post_en && (post_idx >= LIMIT);
    assign clr_bad  = clr_en  && (clr_idx  >= LIMIT);

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        assign set_vec[i]  = (post_en && (post_idx == IDX_W'(i)))
                           || (hit && (pos == POS_W'(i)));
        assign kill_vec[i] = clr_en && (clr_idx == IDX_W'(i));

        always_comb begin
            if (clr_all) begin
                pend_d[i] = 1'b0;
            end else if (kill_vec[i]) begin
                pend_d[i] = 1'b0;
            end else if (set_vec[i]) begin
                pend_d[i] = 1'b1;
            end else begin
                pend_d[i] = pend_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            idx_err_q <= 1'b0;
        end else begin
            pend_q    <= pend_d;
            idx_err_q <= post_bad || clr_bad;
        end
    end

    AST_CLRALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (pend_q == '0)); // R2
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !clr_bad) |=> !pend_q[$past(clr_idx[POS_W-1:0])]); // R3
    AST_BADIDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((post_en || clr_en) && (!post_en || post_bad) && (!clr_en || clr_bad)
         && !clr_all && !hit) |=> $stable(pend_q)); // R4
    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (post_bad || clr_bad) |=> idx_err_q); // R4
    AST_TIMER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr_all && !(clr_en && clr_idx == {1'b0, pos}))
        |=> pend_q[$past(pos)]); // R6

endmodule

// File: rtl/irq_gate_fsm.sv
module irq_gate_fsm
    import irq_gate_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gie,
    input  logic             erl,
    input  logic             exl,
    input  logic [NBITS-1:0] mask,
    input  logic [NBITS-1:0] pend,
    output logic             take_irq,
    output logic [NBITS-1:0] hnd_mask,
    output logic [NBITS-1:0] hnd_pend
);

    gate_state_e state_q;
    gate_state_e state_d;
    logic        open_now;
    logic [NBITS-1:0] live;

    assign live     = mask & pend;
    assign open_now = gie && !erl && !exl && (live != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: if (open_now)  state_d = GATE_FIRE;
            GATE_FIRE: if (!open_now) state_d = GATE_IDLE;
            default:   state_d = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hnd_mask <= '0;
            hnd_pend <= '0;
        end else begin
            hnd_mask <= mask;
            hnd_pend <= live;
        end
    end

    assign take_irq = (state_q == GATE_FIRE);

    AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> $past(gie && !erl && !exl)); // R8
    AST_TAKE_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (hnd_pend != '0)); // R9
    AST_STATUS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (erl || exl || !gie) |=> !take_irq); // R8

endmodule

// File: rtl/core_irq_ctl.sv
module core_irq_ctl #(
    parameter int NBITS = 8,
    parameter int CNT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       post_en,
    input  logic [$clog2(NBITS):0]     post_idx,
    input  logic                       clr_en,
    input  logic [$clog2(NBITS):0]     clr_idx,
    input  logic                       clr_all,
    input  logic                       cnt_en,
    input  logic                       cnt_wr,
    input  logic [CNT_W-1:0]           cnt_wdata,
    input  logic                       cmp_wr,
    input  logic [CNT_W-1:0]           cmp_wdata,
    input  logic                       pos_wr,
    input  logic [$clog2(NBITS)-1:0]   pos_wdata,
    input  logic                       gie,
    input  logic                       erl,
    input  logic                       exl,
    input  logic [NBITS-1:0]           mask,
    output logic [NBITS-1:0]           pending,
    output logic                       any_pend,
    output logic                       take_irq,
    output logic [NBITS-1:0]           hnd_mask,
    output logic [NBITS-1:0]           hnd_pend,
    output logic                       idx_err,
    output logic [CNT_W-1:0]           count
);

    localparam int POS_W = $clog2(NBITS);
    localparam int IDX_W = POS_W + 1;

    logic             hit;
    logic [POS_W-1:0] pos_q;

    cyc_timer #(.CNT_W(CNT_W), .POS_W(POS_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .pos_wr    (pos_wr),
        .pos_wdata (pos_wdata),
        .count_q   (count),
        .pos_q     (pos_q),
        .hit       (hit)
    );

    pend_field #(.NBITS(NBITS), .IDX_W(IDX_W), .POS_W(POS_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_en   (post_en),
        .post_idx  (post_idx),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .clr_all   (clr_all),
        .hit       (hit),
        .pos       (pos_q),
        .pend_q    (pending),
        .idx_err_q (idx_err)
    );

    irq_gate_fsm #(.NBITS(NBITS)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gie      (gie),
        .erl      (erl),
        .exl      (exl),
        .mask     (mask),
        .pend     (pending),
        .take_irq (take_irq),
        .hnd_mask (hnd_mask),
        .hnd_pend (hnd_pend)
    );

    // timer match counts as pending before it is merged into the flags
    assign any_pend = (pending != '0) || hit;

    AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> any_pend); // R10

endmodule

// File: tb/core_irq_ctl_tb.sv
`timescale 1ns/1ps
module core_irq_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_en = 0, clr_en = 0, clr_all = 0;
    logic [3:0]  post_idx = 0, clr_idx = 0;
    logic        cnt_en = 0, cnt_wr = 0, cmp_wr = 0, pos_wr = 0;
    logic [31:0] cnt_wdata = 0, cmp_wdata = 0;
    logic [2:0]  pos_wdata = 0;
    logic        gie = 0, erl = 0, exl = 0;
    logic [7:0]  mask = 0;
    logic [7:0]  pending, hnd_mask, hnd_pend;
    logic        any_pend, take_irq, idx_err;
    logic [31:0] count;

    always #4 clk = ~clk;

    core_irq_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .post_en(post_en), .post_idx(post_idx),
        .clr_en(clr_en), .clr_idx(clr_idx), .clr_all(clr_all),
        .cnt_en(cnt_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .pos_wr(pos_wr), .pos_wdata(pos_wdata),
        .gie(gie), .erl(erl), .exl(exl), .mask(mask),
        .pending(pending), .any_pend(any_pend), .take_irq(take_irq),
        .hnd_mask(hnd_mask), .hnd_pend(hnd_pend),
        .idx_err(idx_err), .count(count)
    );

    typedef struct {
        logic [7:0]  pend;
        logic        take;
        logic        err;
        logic [31:0] cnt;
        logic [7:0]  hm;
        logic [7:0]  hp;
        string       req;
        int          due;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // reference state, built from the requirements
    logic [7:0]  m_pend = 0;
    logic [31:0] m_cnt = 0, m_cmp = 0;
    logic [2:0]  m_pos = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops items whose cycle has come
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.req, "pending",  {24'd0, pending},  {24'd0, e.pend});
            chk(e.req, "take_irq", {31'd0, take_irq}, {31'd0, e.take});
            chk(e.req, "idx_err",  {31'd0, idx_err},  {31'd0, e.err});
            chk(e.req, "count",    count,             e.cnt);
            chk(e.req, "hnd_mask", {24'd0, hnd_mask}, {24'd0, e.hm});
            chk(e.req, "hnd_pend", {24'd0, hnd_pend}, {24'd0, e.hp});
        end
    end

    // driver: inputs already applied; predict, push, advance one cycle
    task automatic tick(input string req);
        exp_t e;
        logic match;
        logic [7:0] np;
        match = (m_cnt == m_cmp) && (m_cnt != 0);
        np = m_pend;
        if (match) np[m_pos] = 1'b1;
        if (post_en && post_idx < 8) np[post_idx[2:0]] = 1'b1;
        if (clr_en && clr_idx < 8) np[clr_idx[2:0]] = 1'b0;
        if (clr_all) np = 8'h00;
        e.take = gie && !erl && !exl && ((mask & m_pend) != 0);
        e.hm   = mask;
        e.hp   = mask & m_pend;
        e.err  = (post_en && post_idx >= 8) || (clr_en && clr_idx >= 8);
        e.pend = np;
        if (cnt_wr) m_cnt = cnt_wdata;
        else if (cnt_en) m_cnt = m_cnt + 1;
        if (cmp_wr) m_cmp = cmp_wdata;
        if (pos_wr) m_pos = pos_wdata;
        m_pend = np;
        e.cnt = m_cnt;
        e.req = req;
        e.due = cyc + 1;
        sb.push_back(e);
        @(posedge clk);
        #1;
        post_en = 0; clr_en = 0; clr_all = 0;
        cnt_wr = 0; cmp_wr = 0; pos_wr = 0;
    endtask

    task automatic check_any(input string req);
        logic exp_any;
        exp_any = (m_pend != 0) || ((m_cnt == m_cmp) && (m_cnt != 0));
        chk(req, "any_pend", {31'd0, any_pend}, {31'd0, exp_any});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "pending", {24'd0, pending}, 32'd0);
        chk("R11", "take_irq", {31'd0, take_irq}, 32'd0);
        chk("R11", "count", count, 32'd0);
        chk("R11", "idx_err", {31'd0, idx_err}, 32'd0);
        rst_n = 1'b1;
        tick("R11");

        // R1: single posts
        post_en = 1; post_idx = 0; tick("R1");
        post_en = 1; post_idx = 3; tick("R1");
        post_en = 1; post_idx = 7; tick("R1");
        // R2: single clear
        clr_en = 1; clr_idx = 3; tick("R2");
        // R3: post and clear on the same flag
        post_en = 1; post_idx = 5; clr_en = 1; clr_idx = 5; tick("R3");
        // R4: indexes out of range, truncation would hit flags 1 and 0
        post_en = 1; post_idx = 9; tick("R4");
        clr_en = 1; clr_idx = 8; tick("R4");
        tick("R4");
        // R2: clear-all beats a post
        post_en = 1; post_idx = 2; clr_all = 1; tick("R2");

        // R8/R9: delivery gating
        post_en = 1; post_idx = 4; tick("R1");
        mask = 8'h10; gie = 1; tick("R8");
        tick("R8");
        erl = 1; tick("R8");
        tick("R8");
        erl = 0; exl = 1; tick("R8");
        tick("R8");
        exl = 0; mask = 8'h0f; tick("R9");
        tick("R9");
        mask = 8'hff; tick("R9");
        clr_all = 1; tick("R2");
        tick("R8");

        // R6/R7: timer match on flag 6
        cmp_wr = 1; cmp_wdata = 32'd10; pos_wr = 1; pos_wdata = 3'd6;
        cnt_wr = 1; cnt_wdata = 32'd5; tick("R5");
        cnt_en = 1;
        for (int k = 0; k < 8; k++) tick("R6");
        tick("R7");
        tick("R7");
        // R3: clear on timer flag in the match cycle
        cnt_en = 0; clr_all = 1; tick("R2");
        cnt_wr = 1; cnt_wdata = 32'd10; tick("R5");
        check_any("R10");
        clr_en = 1; clr_idx = 6; tick("R3");
        cnt_wr = 1; cnt_wdata = 32'd11; tick("R5");
        // R6: zero equals zero sets nothing
        clr_all = 1; cmp_wr = 1; cmp_wdata = 32'd0;
        cnt_wr = 1; cnt_wdata = 32'd0; tick("R6");
        check_any("R10");
        tick("R6");
        tick("R6");
        // R5: wrap
        cnt_wr = 1; cnt_wdata = 32'hffff_fffe; tick("R5");
        cnt_en = 1; tick("R5");
        tick("R5");
        tick("R5");
        cnt_en = 0; tick("R5");
        tick("R5");
        check_any("R10");

        repeat (2) @(posedge clk);
        #1;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule